// File: doc/BRIEF.md
# Serial Memory Slave Protocol Engine

This block is the bus-facing controller of a 4096 x 8 serial memory. It sits on a fast system clock and watches the two-wire bus lines (SCL, SDA). Each line passes through a two-flop synchronizer and a glitch filter before its edges are decoded. The engine tracks START and STOP conditions and compares the device address byte with a fixed code and three strap pins. For a write it takes two address bytes and then any number of data bytes. For a read it fetches bytes from the array and shifts them out. SDA is driven only as an open-drain pull-down enable.

The engine holds the current-address pointer. Each accepted write byte appears for one cycle on a write strobe with its address, for the page buffer. A STOP after at least one data byte raises a one-cycle end pulse, which the write controller uses to start its internal cycle. While that controller reports busy, the engine refuses its device address, so the master can poll with repeated address bytes until it gets an acknowledge. The array read port is combinational: `rd_data_i` must reflect `rd_addr_o` within the same clock cycle.

Top module: `i2cm_slave`

## Requirements
- R1: START (SDA falls while SCL is high) opens a transaction. STOP (SDA rises while SCL is high) returns the engine to idle with SDA released. Bytes clocked with no START before them get no acknowledge.
- R2: The device byte is taken MSB first. Bits 7..4 must be 1010, bits 3..1 must equal `strap_i[2:0]`, and bit 0 selects read (1) or write (0). On a mismatch the engine sends no acknowledge and leaves SDA alone until the next START.
- R3: Incoming bits are sampled on the SCL rising edge. The engine changes `sda_oe_o` only while SCL is low. It acknowledges by pulling SDA low for the ninth clock of a byte.
- R4: A write carries the high address byte, then the low address byte, then data. The top four bits of the high byte are ignored. Each data byte is acknowledged and shown for one cycle on `wr_valid_o` with its address on `wr_addr_o`.
- R5: During a write, the pointer advances only in its low five bits (a 32-byte page), wrapping from offset 31 back to offset 0 of the same page.
- R6: `wr_end_o` pulses once after a STOP that follows at least one data byte. An address-only write does not produce it.
- R7: A read with no address phase before it returns the byte at the current pointer, which is one past the last byte accessed.
- R8: An address-only write, then a repeated START and a read, returns the byte at the newly loaded address.
- R9: When the master acknowledges a read byte, the next byte follows, and the address wraps from 4095 to 0. A master non-acknowledge ends the read.
- R10: While `busy_i` is high, the device address byte is not acknowledged.
- R11: A pulse on either line shorter than `FILT_LEN` clock cycles is ignored.
- R12: A START in the middle of a byte discards the partial byte and restarts reception of the device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 3 | Device address strap pins |
| busy_i | input | 1 | Internal write cycle in progress |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| rd_addr_o | output | 12 | Array read address (current pointer) |
| rd_data_i | input | 8 | Array read data for rd_addr_o, same cycle |
| wr_valid_o | output | 1 | One-cycle strobe for an accepted data byte |
| wr_addr_o | output | 12 | Address of the strobed data byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_end_o | output | 1 | One-cycle pulse: write session closed by STOP |

## Verification
Every bus event reaches the control logic about FILT_LEN plus three cycles after the raw line moves: two synchronizer flops, the filter run, and one edge register. A new SDA drive therefore follows an SCL falling edge by that delay. The write strobe follows the falling edge after the eighth bit by the same delay. The bench holds each SCL phase for 40 cycles and samples SDA at the middle of the high phase, so each acknowledge or read bit is read long after it has settled. A monitor on the falling clock edge pops one expected address/data pair from a queue for each write strobe, and checks the queue is empty once each STOP has settled.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_ACK, ST_TX, ST_MACK
  } i2cm_state_e;
endpackage

// File: rtl/i2cm_filt.sv
module i2cm_filt #(
  parameter int FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic s1_q, s2_q, out_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      out_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      s1_q <= in_i;
      s2_q <= s1_q;
      if (s2_q != out_q) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          out_q <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign out_o = out_q;

  // a fresh difference never passes through in a single cycle
  p_glitch_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_q != out_q) && $past(s2_q == out_q) |=> $stable(out_q));
endmodule

// File: rtl/i2cm_bus_evt.sv
module i2cm_bus_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter int         PAGE_W   = 5,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_end_o
);
  localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [PAGE_W-1:0] ONE_P = {{(PAGE_W-1){1'b0}}, 1'b1};

  i2cm_state_e state_q, ret_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        sh_q, hi_q;
  logic [ADDR_W-1:0] ptr_q, wr_addr_q;
  logic [7:0]        wr_data_q;
  logic              sda_oe_q, wr_valid_q, wr_end_q, wrote_q, mack_q;

  logic              dev_hit;
  logic [15:0]       addr_full;
  logic [ADDR_W-1:0] ptr_page_nxt;

  assign dev_hit      = (sh_q[7:4] == DEV_CODE) && (sh_q[3:1] == strap_i) && !busy_i;
  assign addr_full    = {hi_q, sh_q};
  assign ptr_page_nxt = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + ONE_P};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ret_q      <= ST_IDLE;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      hi_q       <= '0;
      ptr_q      <= '0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      sda_oe_q   <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_end_q   <= 1'b0;
      wrote_q    <= 1'b0;
      mack_q     <= 1'b1;
    end else begin
      wr_valid_q <= 1'b0;
      wr_end_q   <= 1'b0;
      if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
        wr_end_q <= wrote_q;
        wrote_q  <= 1'b0;
      end else if (start_i) begin
        state_q   <= ST_DEV;
        bit_cnt_q <= '0;
        sda_oe_q  <= 1'b0;
        wrote_q   <= 1'b0;
      end else begin
        case (state_q)
          ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
            if (scl_rise_i && bit_cnt_q != 4'd8) begin
              sh_q      <= {sh_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              bit_cnt_q <= '0;
              if (state_q == ST_DEV) begin
                if (dev_hit) begin
                  sda_oe_q <= 1'b1;
                  state_q  <= ST_ACK;
                  ret_q    <= sh_q[0] ? ST_TX : ST_AHI;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                sda_oe_q <= 1'b1;
                state_q  <= ST_ACK;
                if (state_q == ST_AHI) begin
                  hi_q  <= sh_q;
                  ret_q <= ST_ALO;
                end else if (state_q == ST_ALO) begin
                  ptr_q <= addr_full[ADDR_W-1:0];
                  ret_q <= ST_WDAT;
                end else begin
                  wr_valid_q <= 1'b1;
                  wr_addr_q  <= ptr_q;
                  wr_data_q  <= sh_q;
                  ptr_q      <= ptr_page_nxt;
                  wrote_q    <= 1'b1;
                  ret_q      <= ST_WDAT;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (ret_q == ST_TX) begin
                sh_q     <= rd_data_i;
                sda_oe_q <= !rd_data_i[7];
                ptr_q    <= ptr_q + ONE_A;
                state_q  <= ST_TX;
              end else begin
                sda_oe_q <= 1'b0;
                state_q  <= ret_q;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bit_cnt_q == 4'd7) begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_MACK;
              end else begin
                sh_q      <= {sh_q[6:0], 1'b0};
                sda_oe_q  <= !sh_q[6];
                bit_cnt_q <= bit_cnt_q + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack_q <= sda_i;
            end else if (scl_fall_i) begin
              if (!mack_q) begin
                sh_q      <= rd_data_i;
                sda_oe_q  <= !rd_data_i[7];
                ptr_q     <= ptr_q + ONE_A;
                bit_cnt_q <= '0;
                state_q   <= ST_TX;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = sda_oe_q;
  assign rd_addr_o  = ptr_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign wr_end_o   = wr_end_q;

  p_oe_scl_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_q != $past(sda_oe_q)) && !$past(start_i) && !$past(stop_i) |-> !$past(scl_i));

  p_stop_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE) && !sda_oe_q);

  p_busy_nack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEV) && scl_fall_i && (bit_cnt_q == 4'd8) && busy_i && !start_i && !stop_i
    |=> !sda_oe_q);

  p_wr_from_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_q |-> (state_q == ST_ACK) && (ret_q == ST_WDAT));

  p_end_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_end_q |-> (state_q == ST_IDLE) && !wr_valid_q);
endmodule

// File: rtl/i2cm_slave.sv
module i2cm_slave #(
  parameter int         ADDR_W   = 12,
  parameter int         PAGE_W   = 5,
  parameter int         FILT_LEN = 4,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_end_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  logic scl_rise, scl_fall, start, stop;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2cm_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (raw[g]),
      .out_o (filt[g])
    );
  end

  i2cm_bus_evt u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (filt[0]),
    .sda_i     (filt[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start),
    .stop_o    (stop)
  );

  i2cm_ctrl #(
    .ADDR_W  (ADDR_W),
    .PAGE_W  (PAGE_W),
    .DEV_CODE(DEV_CODE)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (filt[0]),
    .sda_i     (filt[1]),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start),
    .stop_i    (stop),
    .strap_i   (strap_i),
    .busy_i    (busy_i),
    .sda_oe_o  (sda_oe_o),
    .rd_addr_o (rd_addr_o),
    .rd_data_i (rd_data_i),
    .wr_valid_o(wr_valid_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .wr_end_o  (wr_end_o)
  );
endmodule

// File: tb/i2cm_slave_test.sv
module i2cm_slave_test;
  localparam int Q = 20;  // quarter of an SCL period, in clocks

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic busy = 1'b0;
  logic sda_oe, wr_valid, wr_end;
  logic [11:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic sda_line;

  logic [7:0] mem [4096];
  logic [19:0] exp_q[$];
  int errors = 0, checks = 0, end_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;
  assign rd_data  = mem[rd_addr];

  i2cm_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(strap), .busy_i(busy), .sda_oe_o(sda_oe),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_end_o(wr_end)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCL clock; optional short SCL glitch during the low phase
  task automatic bit_clk(input logic b, input bit glitch, output logic s);
    m_scl = 1'b0; wt(Q);
    m_sda = b;
    if (glitch) begin
      wt(5); m_scl = 1'b1; wt(2); m_scl = 1'b0; wt(Q - 7);
    end else wt(Q);
    m_scl = 1'b1; wt(Q);
    s = sda_line; wt(Q);
  endtask

  task automatic do_start();
    m_scl = 1'b0; wt(Q); m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q);
  endtask

  task automatic do_stop();
    m_scl = 1'b0; wt(Q); m_sda = 1'b0; wt(Q);
    m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gbit, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], (i == gbit), s);
    bit_clk(1'b1, 1'b0, ack);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(1'b1, 1'b0, s);
      b[i] = s;
    end
    bit_clk(mack, 1'b0, s);
  endtask

  // address phase of a write; checks every acknowledge
  task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo, input string req);
    logic a;
    do_start();
    send_byte(8'hAA, -1, a); chk(a == 1'b0, req, a, 0);
    send_byte(hi, -1, a);    chk(a == 1'b0, req, a, 0);
    send_byte(lo, -1, a);    chk(a == 1'b0, req, a, 0);
  endtask

  task automatic push_exp(input logic [11:0] base, input int k, input logic [7:0] d);
    logic [11:0] ad;
    ad = {base[11:5], 5'(base[4:0] + k)};
    exp_q.push_back({ad, d});
  endtask

  // scoreboard monitor for the write strobe; also stands in for the page buffer
  always @(negedge clk) begin
    if (rst_ni && wr_valid) begin
      logic [19:0] e;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected write strobe", {wr_addr, wr_data}, 0);
      end else begin
        e = exp_q.pop_front();
        chk({wr_addr, wr_data} == e, "R4/R5 write strobe", {wr_addr, wr_data}, e);
      end
      mem[wr_addr] = wr_data;
    end
    if (rst_ni && wr_end) end_cnt++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    int e0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    wt(5);
    chk(sda_oe == 1'b0 && wr_valid == 1'b0 && wr_end == 1'b0, "R1 reset state",
        {sda_oe, wr_valid, wr_end}, 0);
    rst_ni = 1'b1;
    wt(10);

    // R1: matching byte without START gets no acknowledge
    send_byte(8'hAA, -1, a);
    chk(a == 1'b1, "R1 no START no ack", a, 1);
    do_stop();

    // R2: wrong strap bits
    do_start();
    send_byte(8'hA0, -1, a);
    chk(a == 1'b1, "R2 address mismatch nack", a, 1);
    send_byte(8'h00, -1, a);
    chk(a == 1'b1, "R2 silent until START", a, 1);
    do_stop();

    // R4: write two bytes, upper nibble of high address ignored -> 0x123
    e0 = end_cnt;
    addr_phase(8'hF1, 8'h23, "R4 address ack");
    push_exp(12'h123, 0, 8'hA5); send_byte(8'hA5, -1, a); chk(a == 1'b0, "R4 data ack", a, 0);
    push_exp(12'h123, 1, 8'h5A); send_byte(8'h5A, -1, a); chk(a == 1'b0, "R4 data ack", a, 0);
    do_stop(); wt(20);
    chk(exp_q.size() == 0, "R4 all strobes seen", exp_q.size(), 0);
    chk(end_cnt == e0 + 1, "R6 end pulse after STOP", end_cnt - e0, 1);

    // R5: page wrap from offset 30, plus an SCL glitch inside a byte (R11)
    addr_phase(8'h00, 8'h3E, "R5 address ack");
    push_exp(12'h03E, 0, 8'h11); send_byte(8'h11, -1, a);
    push_exp(12'h03E, 1, 8'h22); send_byte(8'h22, 3, a);
    chk(a == 1'b0, "R11 glitched byte ack", a, 0);
    push_exp(12'h03E, 2, 8'h33); send_byte(8'h33, -1, a);
    do_stop(); wt(20);
    chk(exp_q.size() == 0, "R5 page wrap strobes", exp_q.size(), 0);
    chk(mem[12'h020] == 8'h33, "R5 wrap lands at page start", mem[12'h020], 8'h33);

    // R7: current-address read -> 0x021
    do_start();
    send_byte(8'hAB, -1, a); chk(a == 1'b0, "R7 read address ack", a, 0);
    recv_byte(1'b1, b);
    chk(b == mem[12'h021], "R7 current address read", b, mem[12'h021]);
    do_stop();

    // R8: selective read at 0x200, dummy write gives no end pulse (R6)
    e0 = end_cnt;
    addr_phase(8'h02, 8'h00, "R8 address ack");
    do_start();
    send_byte(8'hAB, -1, a); chk(a == 1'b0, "R8 read address ack", a, 0);
    recv_byte(1'b1, b);
    chk(b == mem[12'h200], "R8 selective read", b, mem[12'h200]);
    do_stop(); wt(20);
    chk(end_cnt == e0, "R6 no end pulse for dummy write", end_cnt - e0, 0);

    // R9: sequential read wraps 0xFFF -> 0x000
    addr_phase(8'h0F, 8'hFF, "R9 address ack");
    do_start();
    send_byte(8'hAB, -1, a);
    recv_byte(1'b0, b); chk(b == mem[12'hFFF], "R9 seq byte 0", b, mem[12'hFFF]);
    recv_byte(1'b0, b); chk(b == mem[12'h000], "R9 seq wrap", b, mem[12'h000]);
    recv_byte(1'b1, b); chk(b == mem[12'h001], "R9 seq byte 2", b, mem[12'h001]);
    do_stop();
    do_start();
    send_byte(8'hAB, -1, a);
    recv_byte(1'b1, b); chk(b == mem[12'h002], "R9 pointer after NACK", b, mem[12'h002]);
    do_stop();

    // R10: busy blocks the device address, then polling succeeds
    busy = 1'b1;
    do_start(); send_byte(8'hAA, -1, a);
    chk(a == 1'b1, "R10 busy nack", a, 1);
    do_stop();
    busy = 1'b0;
    do_start(); send_byte(8'hAA, -1, a);
    chk(a == 1'b0, "R10 ack after busy", a, 0);
    do_stop();

    // R12: START in mid-byte restarts address reception
    do_start();
    for (int i = 0; i < 4; i++) bit_clk(1'b1, 1'b0, a);
    addr_phase(8'h01, 8'h00, "R12 restart address ack");
    do_start();
    send_byte(8'hAB, -1, a);
    recv_byte(1'b1, b); chk(b == mem[12'h100], "R12 read after restart", b, mem[12'h100]);
    do_stop(); wt(20);
    chk(sda_oe == 1'b0, "R1 released after STOP", sda_oe, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule